// File: doc/BRIEF.md
# Tree Heap Streaming Sorter

This block sorts a batch of unsigned numbers held in a binary tree of identical compare-and-store nodes. While the mode pin selects writing, one number enters per clock at the root. Each occupied node keeps the larger of what it holds and what arrives. It hands the smaller one down to one of its two children, and it swaps between the left and the right child each time it does so, which keeps the tree filling evenly. The insertion settles through the whole root-to-leaf path within the same clock.

While the mode pin selects reading, the output shows the largest stored value, and each clock edge removes it. The root refills from whichever child holds the larger value. That child refills from its own children in turn, so only one path of the tree changes per clock. A batch of N values, with N no larger than the capacity, goes in over N clocks and comes back in descending order over the next N clocks, with no gap between the two phases. A batch must be read out completely before the next batch is written. The data path is a plain one-word-per-clock stream with no handshake. Hold is the only form of back-pressure: while it is high, nothing moves and the output stays as it is.

Top module: `heap_sorter`

## Requirements
- R1: After reset every node is empty and `dout` is zero.
- R2: While `hold` is 1 no stored value, occupancy or output changes, whatever `wr_mode` and `din` carry.
- R3: With `hold` 0 and `wr_mode` 1, each clock edge stores `din`. Up to 2^DEPTH-1 values (15 at the defaults) are all kept.
- R4: `dout` always equals the largest value currently stored, or zero when the tree is empty. A write therefore never lowers `dout`, and after a write `dout` is at least the value written.
- R5: With `hold` 0 and `wr_mode` 0, each clock edge removes the value shown on `dout`. The values shown over consecutive reads are non-increasing, and a full readout returns exactly the written batch.
- R6: In the first read cycle, immediately after the last write, `dout` already shows the batch maximum, with no extra latency cycle.
- R7: A read on an empty tree leaves it empty and `dout` stays zero.
- R8: Comparisons are unsigned, equal values count as keeping the stored one, and duplicates are all preserved, including a batch of identical values.
- R9: After a complete readout, a new batch can be written and sorted with no reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, empties the tree |
| hold | input | 1 | Stall: 1 freezes all state |
| wr_mode | input | 1 | 1 = write `din` each clock, 0 = remove the top value each clock |
| din | input | WIDTH | Value to insert in write mode |
| dout | output | WIDTH | Largest stored value, zero when empty |

## Verification
Two functions can meet in a single cycle. One is a hold that arrives while the mode pin and data keep changing. The other is the switch from the last write straight into the first read, where that read's output depends on an insertion made one edge earlier. The bench inserts hold cycles at random in both phases and drives random mode and data on them. It flips the mode with no idle cycle between phases. A behavioural queue model predicts `dout` on every clock, and any divergence, whether a slip during hold or a late maximum, shows up on the very next sample.

// File: rtl/sorter_pkg.sv
`timescale 1ns/1ps
package sorter_pkg;
  // node count of a full binary tree with the given number of levels
  function automatic int tree_nodes(input int levels);
    return (1 << levels) - 1;
  endfunction
endpackage

// File: rtl/sort_cmp.sv
`timescale 1ns/1ps
// unsigned compare, ties favour operand a
module sort_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         a_ge
);
  assign a_ge = (a >= b);
endmodule

// File: rtl/sort_node.sv
`timescale 1ns/1ps
module sort_node #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic         wr_mode,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  input  logic         pull,
  input  logic         l_v,
  input  logic [W-1:0] l_d,
  input  logic         r_v,
  input  logic [W-1:0] r_d,
  output logic         q_v,
  output logic [W-1:0] q_d,
  output logic         dn_v,
  output logic [W-1:0] dn_d,
  output logic         dn_right,
  output logic         pull_l,
  output logic         pull_r
);
  logic         tog;
  logic         keep_old;
  logic         left_ge;
  logic [W-1:0] winner;
  logic         pick_l;

  // insertion comparator: stored value against arrival
  sort_cmp #(.W(W)) u_wr_cmp (.a(q_d), .b(in_d), .a_ge(keep_old));
  // refill comparator: left child root against right child root
  sort_cmp #(.W(W)) u_rd_cmp (.a(l_d), .b(r_d), .a_ge(left_ge));

  always_comb begin
    winner   = keep_old ? q_d : in_d;
    dn_d     = keep_old ? in_d : q_d;
    dn_v     = wr_mode && in_v && q_v;
    dn_right = tog;
    pick_l   = l_v && (!r_v || left_ge);
    pull_l   = !wr_mode && pull && pick_l;
    pull_r   = !wr_mode && pull && !pick_l && r_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_v <= 1'b0;
      q_d <= '0;
      tog <= 1'b0;
    end else if (!hold) begin
      if (wr_mode) begin
        if (in_v) begin
          if (q_v) begin
            q_d <= winner;
            tog <= ~tog;
          end else begin
            q_v <= 1'b1;
            q_d <= in_d;
          end
        end
      end else if (pull) begin
        if (l_v || r_v) begin
          q_d <= pick_l ? l_d : r_d;
        end else begin
          q_v <= 1'b0;
          q_d <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/heap_sorter.sv
`timescale 1ns/1ps
module heap_sorter
  import sorter_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             wr_mode,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int NODES = tree_nodes(DEPTH);
  localparam int INNER = tree_nodes(DEPTH - 1);

  logic             nv      [NODES];
  logic [WIDTH-1:0] nd      [NODES];
  logic             iv      [NODES];
  logic [WIDTH-1:0] idat    [NODES];
  logic             pl      [NODES];
  logic             dv      [NODES];
  logic [WIDTH-1:0] dd      [NODES];
  logic             dr      [NODES];
  logic             ql      [NODES];
  logic             qr      [NODES];
  logic             lv      [NODES];
  logic [WIDTH-1:0] ld      [NODES];
  logic             rv      [NODES];
  logic [WIDTH-1:0] rd      [NODES];
  logic [NODES-1:0] occ;

  for (genvar k = 0; k < NODES; k++) begin : g_node
    if (k == 0) begin : g_root
      assign iv[k]   = 1'b1;
      assign idat[k] = din;
      assign pl[k]   = 1'b1;
    end else begin : g_child
      localparam int P = (k - 1) / 2;
      localparam bit IS_RIGHT = (k % 2) == 0;
      assign iv[k]   = dv[P] && (dr[P] == IS_RIGHT);
      assign idat[k] = dd[P];
      assign pl[k]   = IS_RIGHT ? qr[P] : ql[P];
    end

    if (k < INNER) begin : g_inner
      assign lv[k] = nv[2*k+1];
      assign ld[k] = nd[2*k+1];
      assign rv[k] = nv[2*k+2];
      assign rd[k] = nd[2*k+2];
    end else begin : g_leaf
      assign lv[k] = 1'b0;
      assign ld[k] = '0;
      assign rv[k] = 1'b0;
      assign rd[k] = '0;
    end

    sort_node #(.W(WIDTH)) u_node (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold    (hold),
      .wr_mode (wr_mode),
      .in_v    (iv[k]),
      .in_d    (idat[k]),
      .pull    (pl[k]),
      .l_v     (lv[k]),
      .l_d     (ld[k]),
      .r_v     (rv[k]),
      .r_d     (rd[k]),
      .q_v     (nv[k]),
      .q_d     (nd[k]),
      .dn_v    (dv[k]),
      .dn_d    (dd[k]),
      .dn_right(dr[k]),
      .pull_l  (ql[k]),
      .pull_r  (qr[k])
    );

    assign occ[k] = nv[k];
  end

  assign dout = nv[0] ? nd[0] : '0;
endmodule

// File: rtl/heap_sorter_chk.sv
`timescale 1ns/1ps
module heap_sorter_chk #(
  parameter int WIDTH = 16,
  parameter int NODES = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hold,
  input logic             wr_mode,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] dout,
  input logic [NODES-1:0] occ
);
  // R2
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(dout) && $stable(occ)));

  // R4
  wr_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && wr_mode) |=> (dout >= $past(din) && dout >= $past(dout)));

  // R3
  wr_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && wr_mode && !(&occ)) |=> ($countones(occ) == $countones($past(occ)) + 1));

  // R5
  rd_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !wr_mode) |=> (dout <= $past(dout)));

  // R5
  rd_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !wr_mode && (|occ)) |=> ($countones(occ) + 1 == $countones($past(occ))));

  // R7
  rd_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !wr_mode && occ == '0) |=> (occ == '0 && dout == '0));
endmodule

bind heap_sorter heap_sorter_chk #(.WIDTH(WIDTH), .NODES(NODES)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold(hold), .wr_mode(wr_mode),
  .din(din), .dout(dout), .occ(occ)
);

// File: tb/heap_sorter_bench.sv
`timescale 1ns/1ps
module heap_sorter_bench;
  localparam int W   = 16;
  localparam int D   = 4;
  localparam int CAP = (1 << D) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         hold = 1'b0;
  logic         wr_mode = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [W-1:0] model[$];

  heap_sorter #(.WIDTH(W), .DEPTH(D)) u_heap_sorter (
    .clk(clk), .rst_n(rst_n), .hold(hold), .wr_mode(wr_mode),
    .din(din), .dout(dout)
  );

  always #5 clk = ~clk;

  function automatic logic [W-1:0] model_top();
    logic [W-1:0] m = '0;
    foreach (model[i]) if (model[i] > m) m = model[i];
    return m;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // sample, compare with model, apply inputs for the next edge, update model
  task automatic step(input string req, input bit h, input bit w,
                      input logic [W-1:0] d, output logic [W-1:0] seen);
    @(negedge clk);
    seen = dout;
    check(req, dout, model_top());
    hold = h;
    wr_mode = w;
    din = d;
    @(posedge clk);
    if (!h) begin
      if (w) model.push_back(d);
      else if (model.size() > 0) begin
        int idx = 0;
        foreach (model[i]) if (model[i] > model[idx]) idx = i;
        model.delete(idx);
      end
    end
  endtask

  task automatic maybe_hold();
    logic [W-1:0] s;
    if ($urandom_range(4) == 0) begin
      step("R2", 1'b1, 1'($urandom), W'($urandom), s);
      @(negedge clk);
      check("R2", dout, model_top());
    end
  endtask

  task automatic run_batch(input int len, input int kind, input string tag);
    logic [W-1:0] b[$];
    logic [W-1:0] got[$];
    logic [W-1:0] s;
    logic [W-1:0] fixed = W'($urandom);
    for (int i = 0; i < len; i++) begin
      case (kind)
        0: b.push_back(W'($urandom));
        1: b.push_back(W'($urandom_range(3)));
        2: b.push_back(fixed);
        default: begin
          case (i % 4)
            0: b.push_back(16'hFFFF);
            1: b.push_back(16'h0000);
            2: b.push_back(16'h8000);
            default: b.push_back(W'($urandom));
          endcase
        end
      endcase
    end
    for (int i = 0; i < len; i++) begin
      maybe_hold();
      step("R4", 1'b0, 1'b1, b[i], s);
    end
    for (int i = 0; i < len; i++) begin
      if (i > 0) maybe_hold();
      step(i == 0 ? "R6" : "R5", 1'b0, 1'b0, '0, s);
      got.push_back(s);
    end
    b.rsort();
    checks++;
    if (got.size() != len) begin
      bad++;
      $display("FAIL R3 actual=%0d expected=%0d", got.size(), len);
    end
    for (int i = 0; i < len; i++) check(tag, got[i], b[i]);
    step("R7", 1'b0, 1'b0, '0, s);
    @(negedge clk);
    check("R7", dout, '0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", dout, '0);
    rst_n = 1'b1;
    for (int len = 1; len <= CAP; len++) begin
      int kind = len % 4;
      string tag = (kind == 0) ? "R5" : "R8";
      if (len > 1 && kind == 0) tag = "R9";
      run_batch(len, kind, tag);
    end
    run_batch(CAP, 2, "R8");
    run_batch(CAP, 3, "R8");
    run_batch(CAP, 0, "R9");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule